// File: doc/BRIEF.md
# Long-Format Two-Stage Access Permission Evaluator

This block decides whether a memory access is allowed by a translation entry that has already been found. It covers both the first translation stage, which is controlled by the operating system, and the second stage, which is controlled by a hypervisor. The entry supplies its fields: a 2-bit access-permission code, separate user and privileged execute-never bits, a 2-bit second-stage access field, and a flag marking the page as non-secure. The request supplies the access kind, the privilege level and the stage select. Two global controls also take part: write-implies-execute-never, and a control that blocks secure-state fetches from non-secure pages.

A request is presented with `req_valid` high for one cycle. One clock edge later, the block raises `rsp_valid` and returns three results. The first is the grant. The second is the read permission of the selected stage. The third says whether a refused access must be reported as a write fault or as a read fault. An atomic access that is refused while read permission was also missing is reported as a read fault. The results stay on the outputs until the next request is taken.

Top module: `perm_eval`

## Requirements
- R1: `rsp_valid` rises one cycle after each clock edge that samples `req_valid` high, and is low after any edge that samples it low. Reset drives `rsp_valid`, `rsp_grant`, `rsp_grant_rd` and `rsp_deny_wr` to 0.
- R2: While no request arrives, `rsp_grant`, `rsp_grant_rd` and `rsp_deny_wr` keep the values of the last response.
- R3: With `req_stage2`=1, read permission is `ent_s2acc[0]` and write permission is `ent_s2acc[1]`. A read (`req_kind`=00) is granted by the read permission and a write (`req_kind`=01) by the write permission.
- R4: A second-stage fetch (`req_kind`=10) is granted only when `ent_s2acc[0]`=1 and `ent_uxn`=0. In this stage `ent_uxn` is the single execute-never bit.
- R5: A second-stage atomic (`req_kind`=11) is granted when either `ent_s2acc` bit is 1.
- R6: With `req_stage2`=0, read and write rights come from `ent_ap` as follows. Code 00 gives privileged read/write and no user access. Code 01 gives read/write at both levels. Code 10 gives privileged read only. Code 11 gives read only at both levels. `req_priv`=1 selects the privileged rights.
- R7: A first-stage privileged fetch needs `ent_pxn`=0 and a code other than 01, the only code that gives the user write access. A user fetch needs `ent_uxn`=0.
- R8: With `ctl_wxn`=1, a first-stage fetch is refused whenever the selected level has write permission.
- R9: With `ctl_sif`=1, a first-stage fetch is refused when `req_secure`=1 and `ent_nonsec`=1.
- R10: A first-stage atomic is granted only if both read and write are permitted at the selected level.
- R11: `rsp_grant_rd` equals the read permission of the selected stage and level. `rsp_deny_wr` is 0 when the access is granted. When it is refused, `rsp_deny_wr` is 1 for a write, 1 for an atomic whose read was permitted, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 atomic |
| req_priv | input | 1 | Privileged access |
| req_stage2 | input | 1 | 1 = evaluate with second-stage rules |
| req_secure | input | 1 | Access issued from secure state |
| ent_ap | input | 2 | First-stage access-permission code |
| ent_uxn | input | 1 | User execute-never (second stage: execute-never) |
| ent_pxn | input | 1 | Privileged execute-never |
| ent_s2acc | input | 2 | Second-stage access field, bit0 read, bit1 write |
| ent_nonsec | input | 1 | Page lies in non-secure space |
| ctl_wxn | input | 1 | Write-implies-execute-never control |
| ctl_sif | input | 1 | Block secure fetch from non-secure page |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | Access granted |
| rsp_grant_rd | output | 1 | Read permission of the selected stage/level |
| rsp_deny_wr | output | 1 | Refusal is reported as a write fault |

## Verification
Every result is due exactly one clock edge after the edge that samples `req_valid`. The bench changes inputs on the falling edge and reads the outputs on the next falling edge, so the single response register has been loaded by then. For R2 the bench idles for several falling edges with `req_valid` low and compares the outputs against the previous response each time. `rsp_valid` is checked to be low on each of those edges.

// File: rtl/perm_eval_pkg.sv
package perm_eval_pkg;

    localparam int AP_W   = 2;
    localparam int S2_W   = 2;
    localparam int KIND_W = 2;

    localparam logic [AP_W-1:0] AP_PRIV_RW = 2'b00;
    localparam logic [AP_W-1:0] AP_ALL_RW  = 2'b01;
    localparam logic [AP_W-1:0] AP_PRIV_RO = 2'b10;
    localparam logic [AP_W-1:0] AP_ALL_RO  = 2'b11;

    localparam int S2_RD_BIT = 0;
    localparam int S2_WR_BIT = 1;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ   = 2'b00,
        ACC_WRITE  = 2'b01,
        ACC_FETCH  = 2'b10,
        ACC_ATOMIC = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        acc_kind_e         kind;
        logic              priv;
        logic              stage2;
        logic              secure;
        logic [AP_W-1:0]   ap;
        logic              uxn;
        logic              pxn;
        logic [S2_W-1:0]   s2acc;
        logic              nonsec;
        logic              wxn;
        logic              sif;
    } perm_req_t;

    typedef struct packed {
        logic grant;
        logic grant_rd;
        logic deny_wr;
    } perm_rsp_t;

    // Read/write rights of a first-stage code at one privilege level.
    function automatic rights_t s1_rw_rights(logic [AP_W-1:0] ap, logic priv);
        rights_t r;
        r.ex = 1'b0;
        if (priv) begin
            r.rd = 1'b1;
            r.wr = (ap == AP_PRIV_RW) || (ap == AP_ALL_RW);
        end else begin
            r.rd = (ap == AP_ALL_RW) || (ap == AP_ALL_RO);
            r.wr = (ap == AP_ALL_RW);
        end
        return r;
    endfunction

    // Picks the grant for an access kind; atomics need both or either right.
    function automatic logic pick_grant(acc_kind_e kind, rights_t r, logic atomic_both);
        logic g;
        unique case (kind)
            ACC_READ:   g = r.rd;
            ACC_WRITE:  g = r.wr;
            ACC_FETCH:  g = r.ex;
            ACC_ATOMIC: g = atomic_both ? (r.rd && r.wr) : (r.rd || r.wr);
            default:    g = 1'b0;
        endcase
        return g;
    endfunction

    // Direction of a refusal: write faults for writes, and for atomics that could read.
    function automatic logic refusal_is_write(acc_kind_e kind, logic grant, logic rd);
        logic w;
        if (grant) begin
            w = 1'b0;
        end else begin
            unique case (kind)
                ACC_WRITE:  w = 1'b1;
                ACC_ATOMIC: w = rd;
                default:    w = 1'b0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/perm_s1_eval.sv
module perm_s1_eval
    import perm_eval_pkg::*;
(
    input  perm_req_t req,
    output perm_rsp_t rsp
);
    rights_t base;
    rights_t rights;
    logic    user_can_write;
    logic    ex_level;
    logic    kill_wxn;
    logic    kill_sif;

    always_comb begin
        base           = s1_rw_rights(req.ap, req.priv);
        user_can_write = (req.ap == AP_ALL_RW);
        // privileged execute is lost on any page the user may write
        ex_level       = req.priv ? (!req.pxn && !user_can_write) : !req.uxn;
        kill_wxn       = req.wxn && base.wr;
        kill_sif       = req.sif && req.secure && req.nonsec;
        rights.rd      = base.rd;
        rights.wr      = base.wr;
        rights.ex      = ex_level && !kill_wxn && !kill_sif;
        rsp.grant      = pick_grant(req.kind, rights, 1'b1);
        rsp.grant_rd   = rights.rd;
        rsp.deny_wr    = refusal_is_write(req.kind, rsp.grant, rights.rd);
    end
endmodule

// File: rtl/perm_s2_eval.sv
module perm_s2_eval
    import perm_eval_pkg::*;
(
    input  perm_req_t req,
    output perm_rsp_t rsp
);
    rights_t rights;

    always_comb begin
        rights.rd    = req.s2acc[S2_RD_BIT];
        rights.wr    = req.s2acc[S2_WR_BIT];
        rights.ex    = rights.rd && !req.uxn;
        rsp.grant    = pick_grant(req.kind, rights, 1'b0);
        rsp.grant_rd = rights.rd;
        rsp.deny_wr  = refusal_is_write(req.kind, rsp.grant, rights.rd);
    end
endmodule

// File: rtl/perm_rsp_reg.sv
module perm_rsp_reg
    import perm_eval_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  perm_rsp_t d,
    output logic      valid,
    output perm_rsp_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import perm_eval_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic             req_priv,
    input  logic             req_stage2,
    input  logic             req_secure,
    input  logic [AP_W-1:0]  ent_ap,
    input  logic             ent_uxn,
    input  logic             ent_pxn,
    input  logic [S2_W-1:0]  ent_s2acc,
    input  logic             ent_nonsec,
    input  logic             ctl_wxn,
    input  logic             ctl_sif,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_grant_rd,
    output logic             rsp_deny_wr
);
    perm_req_t req;
    perm_rsp_t rsp_s1;
    perm_rsp_t rsp_s2;
    perm_rsp_t rsp_sel;
    perm_rsp_t rsp_q;

    always_comb begin
        req.kind   = acc_kind_e'(req_kind);
        req.priv   = req_priv;
        req.stage2 = req_stage2;
        req.secure = req_secure;
        req.ap     = ent_ap;
        req.uxn    = ent_uxn;
        req.pxn    = ent_pxn;
        req.s2acc  = ent_s2acc;
        req.nonsec = ent_nonsec;
        req.wxn    = ctl_wxn;
        req.sif    = ctl_sif;
    end

    perm_s1_eval u_s1 (
        .req (req),
        .rsp (rsp_s1)
    );

    perm_s2_eval u_s2 (
        .req (req),
        .rsp (rsp_s2)
    );

    assign rsp_sel = req.stage2 ? rsp_s2 : rsp_s1;

    perm_rsp_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .load  (req_valid),
        .d     (rsp_sel),
        .valid (rsp_valid),
        .q     (rsp_q)
    );

    assign rsp_grant    = rsp_q.grant;
    assign rsp_grant_rd = rsp_q.grant_rd;
    assign rsp_deny_wr  = rsp_q.deny_wr;
endmodule

// File: rtl/perm_eval_chk.sv
module perm_eval_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       req_priv,
    input logic       req_stage2,
    input logic       req_secure,
    input logic [1:0] ent_ap,
    input logic       ent_uxn,
    input logic       ent_pxn,
    input logic [1:0] ent_s2acc,
    input logic       ent_nonsec,
    input logic       ctl_wxn,
    input logic       ctl_sif,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       rsp_grant_rd,
    input logic       rsp_deny_wr
);
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1

    AST_NO_IDLE_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_grant) && $stable(rsp_grant_rd) && $stable(rsp_deny_wr))); // R2

    AST_S2_READ_BIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stage2) |=> (rsp_grant_rd == $past(ent_s2acc[0]))); // R3

    AST_S2_FETCH_XN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stage2 && req_kind == 2'b10 && ent_uxn) |=> !rsp_grant); // R4

    AST_S2_ATOMIC_ANY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stage2 && req_kind == 2'b11 && ent_s2acc != 2'b00) |=> rsp_grant); // R5

    AST_PRIV_FETCH_USERWR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stage2 && req_kind == 2'b10 && req_priv && ent_ap == 2'b01) |=> !rsp_grant); // R7

    AST_WXN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stage2 && req_kind == 2'b10 && ctl_wxn && ent_ap == 2'b01) |=> !rsp_grant); // R8

    AST_SIF_FETCH: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stage2 && req_kind == 2'b10 && ctl_sif && req_secure && ent_nonsec) |=> !rsp_grant); // R9

    AST_S1_ATOMIC_RO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stage2 && req_kind == 2'b11 && ent_ap[1]) |=> !rsp_grant); // R10

    AST_WRITE_DENY_DIR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'b01) |=> (rsp_grant || rsp_deny_wr)); // R11

    AST_GRANT_NO_DENY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_grant) |-> !rsp_deny_wr); // R11
endmodule

bind perm_eval perm_eval_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_priv     (req_priv),
    .req_stage2   (req_stage2),
    .req_secure   (req_secure),
    .ent_ap       (ent_ap),
    .ent_uxn      (ent_uxn),
    .ent_pxn      (ent_pxn),
    .ent_s2acc    (ent_s2acc),
    .ent_nonsec   (ent_nonsec),
    .ctl_wxn      (ctl_wxn),
    .ctl_sif      (ctl_sif),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .rsp_grant_rd (rsp_grant_rd),
    .rsp_deny_wr  (rsp_deny_wr)
);

// File: tb/perm_eval_tb.sv
module perm_eval_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [1:0] req_kind;
    logic       req_priv;
    logic       req_stage2;
    logic       req_secure;
    logic [1:0] ent_ap;
    logic       ent_uxn;
    logic       ent_pxn;
    logic [1:0] ent_s2acc;
    logic       ent_nonsec;
    logic       ctl_wxn;
    logic       ctl_sif;
    logic       rsp_valid;
    logic       rsp_grant;
    logic       rsp_grant_rd;
    logic       rsp_deny_wr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    perm_eval u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_kind (req_kind),
        .req_priv (req_priv), .req_stage2 (req_stage2), .req_secure (req_secure),
        .ent_ap (ent_ap), .ent_uxn (ent_uxn), .ent_pxn (ent_pxn),
        .ent_s2acc (ent_s2acc), .ent_nonsec (ent_nonsec),
        .ctl_wxn (ctl_wxn), .ctl_sif (ctl_sif),
        .rsp_valid (rsp_valid), .rsp_grant (rsp_grant),
        .rsp_grant_rd (rsp_grant_rd), .rsp_deny_wr (rsp_deny_wr)
    );

    // Expected {grant, grant_rd, deny_wr} derived from the requirement text.
    function automatic logic [2:0] expect_of(logic [1:0] k, logic pv, logic s2, logic sec,
                                             logic [1:0] ap, logic ux, logic px, logic [1:0] acc,
                                             logic ns, logic wx, logic sf);
        logic rd, wr, ex, g, dw;
        if (s2) begin
            rd = acc[0]; wr = acc[1];
            case (k)
                2'b00: g = rd;
                2'b01: g = wr;
                2'b10: g = rd & ~ux;
                default: g = rd | wr;
            endcase
        end else begin
            rd = pv ? 1'b1 : ap[0];
            wr = pv ? ~ap[1] : (ap == 2'b01);
            ex = pv ? (~px & (ap != 2'b01)) : ~ux;
            if (wx && wr) ex = 1'b0;
            if (sf && sec && ns) ex = 1'b0;
            case (k)
                2'b00: g = rd;
                2'b01: g = wr;
                2'b10: g = ex;
                default: g = rd & wr;
            endcase
        end
        dw = ~g & ((k == 2'b01) | ((k == 2'b11) & rd));
        return {g, rd, dw};
    endfunction

    task automatic check3(string tag, logic [2:0] got, logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got grant/rd/denywr=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic check1(string tag, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // Drive one request at a falling edge, check the response one edge later.
    task automatic apply(string tag, logic [1:0] k, logic pv, logic s2, logic sec,
                         logic [1:0] ap, logic ux, logic px, logic [1:0] acc,
                         logic ns, logic wx, logic sf);
        req_valid = 1'b1; req_kind = k; req_priv = pv; req_stage2 = s2; req_secure = sec;
        ent_ap = ap; ent_uxn = ux; ent_pxn = px; ent_s2acc = acc; ent_nonsec = ns;
        ctl_wxn = wx; ctl_sif = sf;
        @(negedge clk);
        req_valid = 1'b0;
        check1({tag, " R1 valid"}, rsp_valid, 1'b1);
        check3(tag, {rsp_grant, rsp_grant_rd, rsp_deny_wr},
               expect_of(k, pv, s2, sec, ap, ux, px, acc, ns, wx, sf));
    endtask

    task automatic t_reset;
        rst = 1'b1; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check1("R1 reset valid", rsp_valid, 1'b0);
        check3("R1 reset outputs", {rsp_grant, rsp_grant_rd, rsp_deny_wr}, 3'b000);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check1("R1 idle after reset", rsp_valid, 1'b0);
    endtask

    task automatic t_s2_rw;
        for (int a = 0; a < 4; a++) begin
            apply("R3 s2 read",  2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'(a), 1'b0, 1'b0, 1'b0);
            apply("R3 s2 write", 2'b01, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 2'(a), 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_s2_fetch;
        for (int a = 0; a < 4; a++)
            for (int x = 0; x < 2; x++)
                apply("R4 s2 fetch", 2'b10, 1'b0, 1'b1, 1'b0, 2'b00, 1'(x), 1'b1, 2'(a), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_s2_atomic;
        for (int a = 0; a < 4; a++)
            apply("R5 s2 atomic", 2'b11, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'(a), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_s1_table;
        for (int ap = 0; ap < 4; ap++)
            for (int pv = 0; pv < 2; pv++)
                for (int k = 0; k < 2; k++)
                    apply("R6 s1 rw table", 2'(k), 1'(pv), 1'b0, 1'b0, 2'(ap), 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_s1_exec;
        for (int ap = 0; ap < 4; ap++)
            for (int pv = 0; pv < 2; pv++)
                for (int xb = 0; xb < 4; xb++)
                    apply("R7 s1 fetch", 2'b10, 1'(pv), 1'b0, 1'b0, 2'(ap), xb[0], xb[1], 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_wxn;
        for (int ap = 0; ap < 4; ap++)
            for (int pv = 0; pv < 2; pv++)
                apply("R8 wxn fetch", 2'b10, 1'(pv), 1'b0, 1'b0, 2'(ap), 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_sif;
        for (int c = 0; c < 8; c++)
            apply("R9 sif fetch", 2'b10, 1'b1, 1'b0, c[0], 2'b10, 1'b0, 1'b0, 2'b00, c[1], 1'b0, c[2]);
    endtask

    task automatic t_s1_atomic;
        for (int ap = 0; ap < 4; ap++)
            for (int pv = 0; pv < 2; pv++)
                apply("R10 R11 s1 atomic", 2'b11, 1'(pv), 1'b0, 1'b0, 2'(ap), 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold;
        logic [2:0] last;
        apply("R2 hold setup", 2'b01, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        last = {rsp_grant, rsp_grant_rd, rsp_deny_wr};
        ent_ap = 2'b11; req_kind = 2'b11; req_priv = 1'b0; ent_s2acc = 2'b00; req_stage2 = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check1("R1 no response when idle", rsp_valid, 1'b0);
            check3("R2 outputs held", {rsp_grant, rsp_grant_rd, rsp_deny_wr}, last);
        end
    endtask

    task automatic t_deny_dir;
        apply("R11 user write denied", 2'b01, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        apply("R11 user atomic no read", 2'b11, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        apply("R11 s2 fetch denied", 2'b10, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_back_to_back;
        req_valid = 1'b1; req_kind = 2'b00; req_priv = 1'b0; req_stage2 = 1'b0; ent_ap = 2'b11;
        @(negedge clk);
        check3("R1 b2b first", {rsp_grant, rsp_grant_rd, rsp_deny_wr}, 3'b110);
        req_kind = 2'b01;
        @(negedge clk);
        req_valid = 1'b0;
        check1("R1 b2b valid", rsp_valid, 1'b1);
        check3("R6 b2b second", {rsp_grant, rsp_grant_rd, rsp_deny_wr}, 3'b011);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_priv = 1'b0; req_stage2 = 1'b0;
        req_secure = 1'b0; ent_ap = 2'b00; ent_uxn = 1'b0; ent_pxn = 1'b0; ent_s2acc = 2'b00;
        ent_nonsec = 1'b0; ctl_wxn = 1'b0; ctl_sif = 1'b0;
        @(negedge clk);
        t_reset();
        t_s2_rw();
        t_s2_fetch();
        t_s2_atomic();
        t_s1_table();
        t_s1_exec();
        t_wxn();
        t_sif();
        t_s1_atomic();
        t_hold();
        t_deny_dir();
        t_back_to_back();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule